// File: doc/BRIEF.md
# Cache Flush Snoop Sequencer

The sequencer takes one flush command, a byte start address and a byte length, and expands it into a run of per-line snoop requests toward a cache hierarchy. Requests go out on a valid/ready channel. Each one carries a line address and a tag. The first request uses tag zero, and every later request steps both the line address and the tag by one.

The block counts requests that have been presented but not yet answered. Each snoop response lowers that count by one. The flush ends once the last request has been accepted and every response has come back. A busy output covers the whole flush and also reflects an external busy input, so the caller can wait on a single signal. A one-cycle done pulse marks the end of the flush. A response that arrives when nothing is outstanding raises a one-cycle error pulse.

Top module: `flush_snoop_seq`

## Requirements
- R1: The number of requests issued for a command equals the byte size divided by LINE_BYTES, rounded up.
- R2: One cycle after an accepted start pulse, request valid is high with line address start_addr / LINE_BYTES (the low address bits are dropped) and tag 0.
- R3: While request valid is high and ready is low, valid, line address and tag hold their values.
- R4: When a request is accepted and lines remain, the next request's line address is one higher and its tag is one higher modulo 2^TAG_W.
- R5: In the cycle after the last line's request is accepted, request valid is low.
- R6: The flush ends at the clock edge where request valid is low and no response is outstanding. From that cycle busy is low, and done is high for exactly that one cycle.
- R7: A start pulse with size zero causes no request and no busy.
- R8: Response ready is high exactly while a flush runs. When no flush runs, request valid and response ready are both low.
- R9: The busy output is the running state ORed with the ext_busy input, with no added delay.
- R10: A start pulse during a running flush is ignored. The line address, tag and request count of the running flush are unchanged.
- R11: A response that arrives when the outstanding count is zero leaves the count at zero and makes rsp_error high for one cycle.
- R12: After reset, request valid, response ready, busy (with ext_busy low), done and rsp_error are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle flush command |
| start_addr | input | ADDR_W | Byte start address |
| start_size | input | SIZE_W | Byte length of the flush |
| ext_busy | input | 1 | Busy indication from outside, ORed into busy |
| snp_req_valid | output | 1 | Snoop request valid |
| snp_req_ready | input | 1 | Snoop request accepted |
| snp_req_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| snp_req_tag | output | TAG_W | Request tag |
| snp_rsp_valid | input | 1 | Snoop response valid |
| snp_rsp_tag | input | TAG_W | Response tag (not used to match requests) |
| snp_rsp_ready | output | 1 | Response accepted, high while running |
| busy | output | 1 | Flush running or ext_busy |
| done | output | 1 | One-cycle pulse when a flush ends |
| rsp_error | output | 1 | One-cycle pulse for a response with none outstanding |

## Verification
Request valid, line address and tag are registered. They first show the command one cycle after the start edge and the next line one cycle after each accepting edge. The bench drives inputs on the falling edge and reads results on the following falling edge, so each accepting edge is checked exactly once. Busy, done and response ready change at the edge that retires the last response. The bench sends each response one cycle after its acceptance, which makes the final drop of busy due one cycle after the last acceptance, and it checks done on that falling edge. Rsp_error appears one cycle after the stray response, and the ext_busy path is checked combinationally after a short settle delay.

// File: rtl/flush_seq_pkg.sv
package flush_seq_pkg;
   typedef enum logic {FS_IDLE = 1'b0, FS_RUN = 1'b1} fs_state_e;
endpackage

// File: rtl/flush_line_calc.sv
module flush_line_calc #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 32,
   parameter int LINE_BYTES = 64,
   localparam int OFS_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFS_W,
   localparam int CNT_W     = SIZE_W - OFS_W + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic [LINE_W-1:0] first_line,
   output logic [CNT_W-1:0]  line_cnt
);
   generate
      if (OFS_W == 0) begin : g_byte_lines
         assign first_line = addr;
         assign line_cnt   = {1'b0, size};
      end else begin : g_wide_lines
         logic [SIZE_W:0] padded;
         logic            unused_lo;
         assign padded     = {1'b0, size} + (SIZE_W+1)'(LINE_BYTES - 1);
         assign line_cnt   = padded[SIZE_W:OFS_W];
         assign first_line = addr[ADDR_W-1:OFS_W];
         assign unused_lo  = ^{addr[OFS_W-1:0], padded[OFS_W-1:0]};
      end
   endgenerate
endmodule

// File: rtl/flush_issue_ctr.sv
module flush_issue_ctr #(
   parameter int LINE_W = 26,
   parameter int TAG_W  = 8,
   parameter int CNT_W  = 27
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [LINE_W-1:0] first_line,
   input  logic [CNT_W-1:0]  line_cnt,
   input  logic              accept,
   output logic              valid,
   output logic [LINE_W-1:0] line,
   output logic [TAG_W-1:0]  tag,
   output logic              step,
   output logic              valid_nxt
);
   logic [CNT_W-1:0] remain;

   always_comb begin
      step = accept && (remain != '0);
      if (load)                          valid_nxt = 1'b1;
      else if (accept && remain == '0)   valid_nxt = 1'b0;
      else                               valid_nxt = valid;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid  <= 1'b0;
         line   <= '0;
         tag    <= '0;
         remain <= '0;
      end else begin
         valid <= valid_nxt;
         if (load) begin
            line   <= first_line;
            tag    <= '0;
            remain <= line_cnt - CNT_W'(1);
         end else if (step) begin
            line   <= line + LINE_W'(1);
            tag    <= tag + TAG_W'(1);
            remain <= remain - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/flush_pend_ctr.sv
module flush_pend_ctr #(
   parameter int CNT_W = 27
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic inc,
   input  logic dec,
   output logic zero_nxt,
   output logic err
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             take;

   always_comb begin
      take = dec && (cnt != '0);
      if (load) cnt_nxt = CNT_W'(1);
      else      cnt_nxt = cnt + CNT_W'(inc) - CNT_W'(take);
      zero_nxt = (cnt_nxt == '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         err <= dec && (cnt == '0);
      end
   end
endmodule

// File: rtl/flush_snoop_seq.sv
module flush_snoop_seq
   import flush_seq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int TAG_W      = 8,
   localparam int OFS_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFS_W,
   localparam int CNT_W     = SIZE_W - OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [SIZE_W-1:0] start_size,
   input  logic              ext_busy,
   output logic              snp_req_valid,
   input  logic              snp_req_ready,
   output logic [LINE_W-1:0] snp_req_line,
   output logic [TAG_W-1:0]  snp_req_tag,
   input  logic              snp_rsp_valid,
   input  logic [TAG_W-1:0]  snp_rsp_tag,
   output logic              snp_rsp_ready,
   output logic              busy,
   output logic              done,
   output logic              rsp_error
);
   generate
      if ((1 << OFS_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (OFS_W >= ADDR_W || OFS_W >= SIZE_W) begin : g_bad_width
         $error("address and size must be wider than the line offset");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
   endgenerate

   fs_state_e         state;
   logic [LINE_W-1:0] first_line;
   logic [CNT_W-1:0]  line_cnt;
   logic              load, accept, step, valid_nxt, zero_nxt, finish;
   logic              unused_tag;

   assign unused_tag = ^snp_rsp_tag;

   flush_line_calc #(
      .ADDR_W     (ADDR_W),
      .SIZE_W     (SIZE_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_calc (
      .addr       (start_addr),
      .size       (start_size),
      .first_line (first_line),
      .line_cnt   (line_cnt)
   );

   assign load   = start && (state == FS_IDLE) && (line_cnt != '0);
   assign accept = snp_req_valid && snp_req_ready;

   flush_issue_ctr #(
      .LINE_W (LINE_W),
      .TAG_W  (TAG_W),
      .CNT_W  (CNT_W)
   ) u_issue (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .first_line (first_line),
      .line_cnt   (line_cnt),
      .accept     (accept),
      .valid      (snp_req_valid),
      .line       (snp_req_line),
      .tag        (snp_req_tag),
      .step       (step),
      .valid_nxt  (valid_nxt)
   );

   flush_pend_ctr #(
      .CNT_W (CNT_W)
   ) u_pend (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .inc      (step),
      .dec      (snp_rsp_valid && snp_rsp_ready),
      .zero_nxt (zero_nxt),
      .err      (rsp_error)
   );

   assign finish = (state == FS_RUN) && !valid_nxt && zero_nxt;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= FS_IDLE;
         done  <= 1'b0;
      end else begin
         done <= finish;
         if (load)        state <= FS_RUN;
         else if (finish) state <= FS_IDLE;
      end
   end

   assign snp_rsp_ready = (state == FS_RUN);
   assign busy          = (state == FS_RUN) || ext_busy;
endmodule

// File: rtl/flush_snoop_seq_chk.sv
module flush_snoop_seq_chk #(
   parameter int SIZE_W = 32,
   parameter int LINE_W = 26,
   parameter int TAG_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic [SIZE_W-1:0] start_size,
   input logic              snp_req_valid,
   input logic              snp_req_ready,
   input logic [LINE_W-1:0] snp_req_line,
   input logic [TAG_W-1:0]  snp_req_tag,
   input logic              snp_rsp_ready,
   input logic              done,
   input logic              rsp_error
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (snp_req_valid && !snp_req_ready) |=> (snp_req_valid && $stable(snp_req_line) && $stable(snp_req_tag))); // R3
   AST_TAG_STEP: assert property (@(posedge clk) disable iff (rst)
      (snp_req_valid && snp_req_ready) |=> (!snp_req_valid || snp_req_tag == $past(snp_req_tag) + TAG_W'(1))); // R4
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
      (snp_req_valid && snp_req_ready) |=> (!snp_req_valid || snp_req_line == $past(snp_req_line) + LINE_W'(1))); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !snp_rsp_ready |-> !snp_req_valid); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> (!snp_req_valid && !snp_rsp_ready)); // R6
   AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (rst)
      (!snp_rsp_ready && start && start_size == '0) |=> !snp_rsp_ready); // R7
   AST_ERR_RUN: assert property (@(posedge clk) disable iff (rst)
      !snp_rsp_ready |=> !rsp_error); // R11
endmodule

bind flush_snoop_seq flush_snoop_seq_chk #(
   .SIZE_W (SIZE_W),
   .LINE_W (LINE_W),
   .TAG_W  (TAG_W)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .start         (start),
   .start_size    (start_size),
   .snp_req_valid (snp_req_valid),
   .snp_req_ready (snp_req_ready),
   .snp_req_line  (snp_req_line),
   .snp_req_tag   (snp_req_tag),
   .snp_rsp_ready (snp_rsp_ready),
   .done          (done),
   .rsp_error     (rsp_error)
);

// File: tb/flush_snoop_seq_bench.sv
module flush_snoop_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int SIZE_W = 32;
   localparam int LBYTES = 16;
   localparam int TAG_W  = 4;
   localparam int LINE_W = ADDR_W - 4;

   typedef struct packed {
      logic [31:0] addr;
      logic [31:0] size;
      logic [31:0] line;
      logic [31:0] n;
      logic        gap;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{32'h100,  32'd16,  32'h10,  32'd1,  1'b0},
      '{32'h105,  32'd1,   32'h10,  32'd1,  1'b0},
      '{32'h200,  32'd17,  32'h20,  32'd2,  1'b1},
      '{32'h40,   32'd48,  32'h4,   32'd3,  1'b0},
      '{32'h1000, 32'd320, 32'h100, 32'd20, 1'b1},
      '{32'h7f0,  32'd31,  32'h7f,  32'd2,  1'b0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [SIZE_W-1:0] start_size = '0;
   logic ext_busy = 1'b0;
   logic snp_req_ready = 1'b0;
   logic snp_rsp_valid = 1'b0;
   logic [TAG_W-1:0] snp_rsp_tag = '0;
   logic snp_req_valid, snp_rsp_ready, busy, done, rsp_error;
   logic [LINE_W-1:0] snp_req_line;
   logic [TAG_W-1:0]  snp_req_tag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flush_snoop_seq #(
      .ADDR_W (ADDR_W), .SIZE_W (SIZE_W), .LINE_BYTES (LBYTES), .TAG_W (TAG_W)
   ) u_flush_snoop_seq (
      .clk (clk), .rst (rst), .start (start), .start_addr (start_addr),
      .start_size (start_size), .ext_busy (ext_busy),
      .snp_req_valid (snp_req_valid), .snp_req_ready (snp_req_ready),
      .snp_req_line (snp_req_line), .snp_req_tag (snp_req_tag),
      .snp_rsp_valid (snp_rsp_valid), .snp_rsp_tag (snp_rsp_tag),
      .snp_rsp_ready (snp_rsp_ready), .busy (busy), .done (done),
      .rsp_error (rsp_error)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs the current flush to its end with ready always high or toggling.
   task automatic drain(input logic [31:0] line0, input int n, input bit gap);
      int idx = 0;
      int cyc = 0;
      bit pend_rsp = 1'b0;
      bit rdy, acc;
      while (busy && cyc < 1000) begin
         check(snp_rsp_ready == 1'b1, "R8 rsp_ready while running", snp_rsp_ready, 1);
         if (snp_req_valid && idx == n) check(1'b0, "R5 valid after last accept", 1, 0);
         rdy = gap ? cyc[0] : 1'b1;
         acc = snp_req_valid && rdy;
         if (acc) begin
            check(snp_req_line == LINE_W'(line0 + 32'(idx)), "R4 line step", snp_req_line, line0 + 32'(idx));
            check(snp_req_tag == TAG_W'(idx), "R4 tag step", snp_req_tag, idx % 16);
            idx++;
         end
         snp_req_ready = rdy;
         snp_rsp_valid = pend_rsp;
         pend_rsp = acc;
         @(negedge clk);
         cyc++;
      end
      snp_req_ready = 1'b0;
      snp_rsp_valid = 1'b0;
      check(done == 1'b1, "R6 done pulse at end", done, 1);
      check(busy == 1'b0 && snp_req_valid == 1'b0, "R6 idle at end", busy, 0);
      check(idx == n, "R1 request count", idx, n);
      @(negedge clk);
      check(done == 1'b0, "R6 done one cycle", done, 0);
   endtask

   task automatic launch(input logic [31:0] a, input logic [31:0] s);
      start = 1'b1; start_addr = a; start_size = s;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R12 reset state
      check(!snp_req_valid && !snp_rsp_ready && !busy && !done && !rsp_error,
            "R12 reset idle", {snp_req_valid, snp_rsp_ready, busy, done, rsp_error}, 0);

      // R9 external busy passes straight through
      ext_busy = 1'b1; #1;
      check(busy == 1'b1, "R9 ext_busy ORed", busy, 1);
      ext_busy = 1'b0; #1;
      check(busy == 1'b0, "R9 ext_busy released", busy, 0);

      // table of flushes: R1 R2 R4 R5 R6
      foreach (VECS[i]) begin
         launch(VECS[i].addr, VECS[i].size);
         check(snp_req_valid && snp_req_line == LINE_W'(VECS[i].line) && snp_req_tag == '0,
               "R2 first request", snp_req_line, VECS[i].line);
         drain(VECS[i].line, int'(VECS[i].n), VECS[i].gap);
      end

      // R7 zero size
      launch(32'h400, 32'd0);
      check(!busy && !snp_req_valid && !snp_rsp_ready, "R7 zero size stays idle",
            {busy, snp_req_valid, snp_rsp_ready}, 0);

      // R10 start while running, R3 hold while stalled
      launch(32'h100, 32'd48);
      launch(32'h800, 32'd16);
      check(snp_req_line == LINE_W'(32'h10) && snp_req_tag == '0 && snp_req_valid,
            "R10 second start ignored / R3 hold", snp_req_line, 32'h10);
      drain(32'h10, 3, 1'b0);

      // R11 stray response
      launch(32'h300, 32'd16);
      snp_rsp_valid = 1'b1;
      @(negedge clk);
      check(rsp_error == 1'b0, "R11 no error while pending", rsp_error, 0);
      @(negedge clk);
      snp_rsp_valid = 1'b0;
      check(rsp_error == 1'b1 && busy, "R11 error on stray response", rsp_error, 1);
      snp_req_ready = 1'b1;
      @(negedge clk);
      snp_req_ready = 1'b0;
      check(!busy && done && !rsp_error, "R11 count held at zero", busy, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule